// File: doc/BRIEF.md
# Triple-Redundant Configuration Cell Chain with Upset Monitor

This block is a chain of configuration cells built to measure single-event upsets. Each cell keeps its bit in three separate storage copies. A plain flip-flop sits beside each cell, and together these flip-flops form a serial shift register. A pattern is shifted in through `ser_in`. A load pulse then copies the whole register into every copy of every cell and records the value each cell is meant to hold. A readback pulse copies each cell's majority value back into the shift register, so the stored pattern can be shifted out on `ser_out` and compared with the pattern that was loaded.

A monitor threads two flags through the cells. The error flag is an OR chain. It rises as soon as any copy anywhere differs from its intended value, and it stays high until the next load or reset. The parity flag is an XOR chain. Each cell contributes a 1 when exactly two of its copies are corrupted, so the flag toggles each time one more cell reaches that state. The block does not correct stored values. A synchronous fault-injection port flips one chosen copy, so that upsets can be produced in simulation.

Top module: `tmr_scan_chain`

## Requirements
- R1: While `rst_n` is low, and after it is released, the shift register, all copies, the intended values and the sticky error bit are 0. So `ser_out`, `error_out` and `parity_out` read 0.
- R2: When `shift_en` is high and neither `load` nor `readback` is high, each clock edge moves the register one place toward cell N_CELLS-1 and takes `ser_in` into cell 0. `ser_out` is the register bit of cell N_CELLS-1, so the first bit shifted in reaches it after N_CELLS shifts. With no control asserted, `ser_out` holds.
- R3: A `load` edge writes each register bit into all three copies and into the intended value of its cell. It also clears the sticky error bit, so right after the load both flags read 0.
- R4: A `readback` edge writes the two-of-three majority of each cell into its register bit. Shifting then presents cell N_CELLS-1 first, then lower cells in descending order.
- R5: One flipped copy in a cell sets `error_out` without changing `parity_out`, and the cell still reads back its loaded value.
- R6: Exactly two flipped copies in one cell toggle `parity_out`, and that cell reads back the inverted value.
- R7: `error_out` is sticky. Once set, it stays 1 even if the faulty copy is flipped back, until the next load or reset.
- R8: The parity contributions of the cells combine by XOR. Two cells that each have exactly two flipped copies leave `parity_out` at 0 while `error_out` is 1.
- R9: With all three copies of a cell flipped, the cell adds nothing to parity, `error_out` is 1, and the cell reads back the inverted value.
- R10: Priority is `load` over `readback` over shift. A load edge leaves the shift register unchanged. An injection with `inj_cell` of N_CELLS or more, or with `inj_copy` equal to 3, changes nothing. On the same edge as a load, an injection is overridden by the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_in | input | 1 | Serial data into cell 0 |
| shift_en | input | 1 | Shift the register by one place |
| load | input | 1 | Copy the register into all cell copies |
| readback | input | 1 | Copy the cell majorities into the register |
| inj_en | input | 1 | Flip one stored copy at this edge |
| inj_cell | input | $clog2(N_CELLS+1) | Cell index for injection |
| inj_copy | input | 2 | Copy index 0 to 2 for injection |
| ser_out | output | 1 | Register bit of the last cell |
| error_out | output | 1 | Sticky flag: any copy differs from its intended value |
| parity_out | output | 1 | XOR over cells of "exactly two copies corrupted" |

## Verification
The assertions assume that the stored copies change only through a load or an injection. Readback and shifting never touch the copies, so parity can move only on an edge that carries one of those two operations. They also assume that a parity change not caused by a load always comes with a corrupted copy. The stimulus drives every control on the falling edge and holds injections to single-cycle pulses, with random cells and copies in range. A few directed out-of-range indices and overlapping control pulses exercise the ignore and priority rules.

// File: rtl/tmr_scan_chain.sv
module tmr_scan_chain #(
  parameter int N_CELLS = 231,
  localparam int CW = $clog2(N_CELLS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ser_in,
  input  logic          shift_en,
  input  logic          load,
  input  logic          readback,
  input  logic          inj_en,
  input  logic [CW-1:0] inj_cell,
  input  logic [1:0]    inj_copy,
  output logic          ser_out,
  output logic          error_out,
  output logic          parity_out
);

  logic [N_CELLS-1:0] sr;
  logic [N_CELLS-1:0] want;
  logic [2:0]         cp [N_CELLS];
  logic [N_CELLS-1:0] maj;
  logic [N_CELLS:0]   err_ch;
  logic [N_CELLS:0]   par_ch;
  logic               err_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      sr <= '0;
    else if (load)
      sr <= sr;
    else if (readback)
      sr <= maj;
    else if (shift_en)
      sr <= {sr[N_CELLS-2:0], ser_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      want <= '0;
      for (int i = 0; i < N_CELLS; i++) cp[i] <= 3'b000;
    end else if (load) begin
      want <= sr;
      for (int i = 0; i < N_CELLS; i++) cp[i] <= {3{sr[i]}};
    end else if (inj_en && (32'(inj_cell) < N_CELLS) && (inj_copy != 2'd3)) begin
      cp[inj_cell][inj_copy] <= ~cp[inj_cell][inj_copy];
    end
  end

  assign err_ch[0] = 1'b0;
  assign par_ch[0] = 1'b0;

  for (genvar g = 0; g < N_CELLS; g++) begin : g_cell
    logic [2:0] diff;
    assign diff         = cp[g] ^ {3{want[g]}};
    assign maj[g]       = (cp[g][0] & cp[g][1]) | (cp[g][0] & cp[g][2]) | (cp[g][1] & cp[g][2]);
    assign err_ch[g+1]  = err_ch[g] | (|diff);
    assign par_ch[g+1]  = par_ch[g] ^ ($countones(diff) == 2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      err_q <= 1'b0;
    else if (load)
      err_q <= 1'b0;
    else if (err_ch[N_CELLS])
      err_q <= 1'b1;
  end

  assign ser_out    = sr[N_CELLS-1];
  assign error_out  = err_q | err_ch[N_CELLS];
  assign parity_out = par_ch[N_CELLS];

endmodule

module tmr_scan_chain_chk (
  input logic clk,
  input logic rst_n,
  input logic shift_en,
  input logic load,
  input logic readback,
  input logic inj_en,
  input logic ser_out,
  input logic error_out,
  input logic parity_out
);

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load && !readback) |=> $stable(ser_out));

  p_load_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (!error_out && !parity_out));

  p_parity_needs_error_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(parity_out) && !$past(load)) |-> error_out);

  p_parity_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!inj_en && !load) |=> $stable(parity_out));

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (error_out && !load) |=> error_out);

endmodule

bind tmr_scan_chain tmr_scan_chain_chk u_chk (
  .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .load(load),
  .readback(readback), .inj_en(inj_en), .ser_out(ser_out),
  .error_out(error_out), .parity_out(parity_out)
);

// File: tb/tmr_scan_chain_tb.sv
`timescale 1ns/1ps
module tmr_scan_chain_tb;
  localparam int N  = 231;
  localparam int CW = $clog2(N + 1);

  logic clk = 1'b0, rst_n = 1'b0, ser_in = 1'b0, shift_en = 1'b0;
  logic load = 1'b0, readback = 1'b0, inj_en = 1'b0;
  logic [CW-1:0] inj_cell = '0;
  logic [1:0] inj_copy = 2'd0;
  logic ser_out, error_out, parity_out;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [N-1:0] pat, pat_b;
  logic [2:0] fl [N];
  bit sticky;

  always #4 clk = ~clk;

  tmr_scan_chain #(.N_CELLS(N)) u_dut (
    .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .shift_en(shift_en),
    .load(load), .readback(readback), .inj_en(inj_en), .inj_cell(inj_cell),
    .inj_copy(inj_copy), .ser_out(ser_out), .error_out(error_out),
    .parity_out(parity_out)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [N-1:0] rnd_pat();
    logic [N-1:0] p;
    for (int i = 0; i < N; i++) p[i] = 1'($urandom_range(0, 1));
    return p;
  endfunction

  function automatic int exp_par();
    int x = 0;
    for (int i = 0; i < N; i++) x ^= int'($countones(fl[i]) == 2);
    return x;
  endfunction

  task automatic shift_in(input logic [N-1:0] p);
    shift_en = 1'b1;
    for (int i = N - 1; i >= 0; i--) begin
      ser_in = p[i];
      tick();
    end
    shift_en = 1'b0;
    ser_in = 1'b0;
  endtask

  task automatic do_load();
    load = 1'b1;
    tick();
    load = 1'b0;
    for (int i = 0; i < N; i++) fl[i] = 3'b000;
    sticky = 0;
  endtask

  task automatic inject(int c, int k);
    inj_en = 1'b1;
    inj_cell = c[CW-1:0];
    inj_copy = k[1:0];
    tick();
    inj_en = 1'b0;
    if (c < N && k < 3) fl[c][k] = ~fl[c][k];
    for (int i = 0; i < N; i++) if (fl[i] != 3'b000) sticky = 1;
  endtask

  task automatic chk_flags(string req);
    check({req, " error_out"}, int'(error_out), int'(sticky));
    check({req, " parity_out"}, int'(parity_out), exp_par());
  endtask

  task automatic read_check(string req, input logic [N-1:0] base);
    int bad = 0;
    readback = 1'b1;
    tick();
    readback = 1'b0;
    shift_en = 1'b1;
    ser_in = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (ser_out !== (base[i] ^ ($countones(fl[i]) >= 2))) bad++;
      tick();
    end
    shift_en = 1'b0;
    check({req, " readback mismatches"}, bad, 0);
  endtask

  initial begin
    #(8 * 200000);
    n_err++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) fl[i] = 3'b000;
    sticky = 0;
    repeat (3) tick();
    check("R1 ser_out in reset", int'(ser_out), 0);
    check("R1 error_out in reset", int'(error_out), 0);
    rst_n = 1'b1;
    tick();
    check("R1 ser_out", int'(ser_out), 0);
    check("R1 error_out", int'(error_out), 0);
    check("R1 parity_out", int'(parity_out), 0);

    // R2: first bit in reaches ser_out after N shifts, holds when idle
    pat = rnd_pat();
    shift_in(pat);
    check("R2 ser_out after N shifts", int'(ser_out), int'(pat[N-1]));
    repeat (5) tick();
    check("R2 ser_out hold", int'(ser_out), int'(pat[N-1]));
    shift_en = 1'b1;
    tick();
    shift_en = 1'b0;
    check("R2 next bit", int'(ser_out), int'(pat[N-2]));

    // R3/R4: clean load then readback in descending order
    pat = rnd_pat();
    shift_in(pat);
    do_load();
    chk_flags("R3 after load");
    read_check("R3 R4 clean", pat);

    // random rounds with faults (R5 R6 R9)
    for (int r = 0; r < 6; r++) begin
      pat = rnd_pat();
      shift_in(pat);
      do_load();
      chk_flags("R3 round load");
      for (int f = 0; f < int'($urandom_range(1, 5)); f++) begin
        inject(int'($urandom_range(0, N - 1)), int'($urandom_range(0, 2)));
        chk_flags("R5/R6/R9 random fault");
      end
      read_check("R5/R6/R9 random", pat);
    end

    // R5 single copy, R7 sticky
    pat = rnd_pat();
    shift_in(pat);
    do_load();
    inject(5, 0);
    chk_flags("R5 single copy");
    check("R5 parity unchanged", int'(parity_out), 0);
    inject(5, 0);
    check("R7 sticky after restore", int'(error_out), 1);
    repeat (3) tick();
    check("R7 sticky held", int'(error_out), 1);
    read_check("R5 readback", pat);

    // R6 two copies, R8 XOR of two cells
    pat = rnd_pat();
    shift_in(pat);
    do_load();
    check("R7 cleared by load", int'(error_out), 0);
    inject(3, 0);
    inject(3, 2);
    check("R6 parity toggled", int'(parity_out), 1);
    inject(10, 1);
    inject(10, 2);
    check("R8 parity cancels", int'(parity_out), 0);
    check("R8 error set", int'(error_out), 1);
    read_check("R6 R8 readback", pat);

    // R9 all three copies
    pat = rnd_pat();
    shift_in(pat);
    do_load();
    inject(7, 0);
    inject(7, 1);
    check("R9 two flipped parity", int'(parity_out), 1);
    inject(7, 2);
    check("R9 three flipped parity", int'(parity_out), 0);
    check("R9 error", int'(error_out), 1);
    read_check("R9 readback", pat);

    // R10 priority and ignored injections
    pat = rnd_pat();
    shift_in(pat);
    do_load();
    pat_b = rnd_pat();
    shift_in(pat_b);
    load = 1'b1; readback = 1'b1; shift_en = 1'b1; ser_in = ~pat_b[N-2];
    inj_en = 1'b1; inj_cell = CW'(4); inj_copy = 2'd1;
    tick();
    load = 1'b0; readback = 1'b0; shift_en = 1'b0; inj_en = 1'b0;
    for (int i = 0; i < N; i++) fl[i] = 3'b000;
    sticky = 0;
    check("R10 load holds register", int'(ser_out), int'(pat_b[N-1]));
    check("R10 load beats injection", int'(error_out), 0);
    inject(N, 0);
    inject(0, 3);
    chk_flags("R10 ignored injection");
    readback = 1'b1; shift_en = 1'b1; ser_in = ~pat_b[N-2];
    tick();
    readback = 1'b0; shift_en = 1'b0;
    check("R10 readback beats shift", int'(ser_out), int'(pat_b[N-1]));
    read_check("R10 loaded pattern", pat_b);

    rst_n = 1'b0;
    tick();
    check("R1 reset clears error", int'(error_out), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule